// File: doc/BRIEF.md
# Transmit Signaling Source Selector

This block builds the signaling byte sent in timeslot 16 of each transmit frame. Every signaling nibble can come from one of two places: the serial signaling stream, or the internal signaling registers. The caller gives the block both candidate bytes for the current frame and says where it is in the 16-frame multiframe. The block picks each nibble from one source and registers the merged byte.

A global mode input turns per-channel selection on. When it is off, every nibble comes from the serial stream. When it is on, a bank of four 8-bit select registers gives one bit per channel. A 1 picks the register source and a 0 picks the serial source. Register k, bit b, belongs to channel 8k+b+1, numbering channels from 1 to 32.

In frames 1 to 15, frame f carries channel f in the upper nibble and channel f+16 in the lower nibble. Frame 0 carries the alignment word and the spare/alarm bits. Its upper nibble follows the select bit of channel 1 and its lower nibble follows the select bit of channel 17. Software therefore sets those two bits so that the first signaling register supplies the alignment pattern. Building the multiframe and computing the CRC are done outside this block.

Top module: `tss_top`

## Requirements
- R1: After reset, `ts16_valid` is 0, `ts16_byte` is 0x00, and all 32 select bits are 0. With the mode on, every nibble then comes from the serial source until a select register is written.
- R2: When `mode_en` is 0, the output byte equals `ser_sig` in every frame, whatever the select bits hold.
- R3: When `mode_en` is 1 and a nibble's governing select bit is 0, that nibble equals the matching nibble of `ser_sig`.
- R4: When `mode_en` is 1 and a nibble's governing select bit is 1, that nibble equals the matching nibble of `reg_sig`.
- R5: In frames 1 to 15, frame f selects with channel f for bits [7:4] and with channel f+16 for bits [3:0]. The select bits of channels 16 and 32 never affect the output.
- R6: In frame 0, bits [7:4] are governed by the select bit of channel 1 and bits [3:0] by the select bit of channel 17. With both bits set, the whole byte equals `reg_sig`.
- R7: The two nibbles of one byte are selected independently, so one byte may mix the serial and register sources.
- R8: The block samples its inputs only when `slot_num` equals 16. `ts16_valid` is high for exactly the one cycle after such a sample. In other cycles `ts16_byte` holds its last value.
- R9: A write with `cfg_we` high loads `cfg_wdata` into select register `cfg_addr`, so that bit b becomes the select bit of channel 8*`cfg_addr`+b+1. The new value takes effect from the next cycle. A sample in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Global enable for per-channel source selection |
| cfg_we | input | 1 | Select register write strobe |
| cfg_addr | input | 2 | Select register index, 0 to 3 |
| cfg_wdata | input | 8 | Select register write data |
| slot_num | input | 5 | Current timeslot number |
| frame_num | input | 4 | Frame position within the multiframe, 0 to 15 |
| ser_sig | input | 8 | Timeslot-16 byte from the serial signaling stream |
| reg_sig | input | 8 | Timeslot-16 byte from the signaling registers for this frame |
| ts16_valid | output | 1 | Merged byte updated in this cycle |
| ts16_byte | output | 8 | Merged timeslot-16 signaling byte |

## Verification
The merged byte and `ts16_valid` are due one clock edge after the cycle in which `slot_num` is 16. The bench drives a sample at a falling edge and checks the result at the next falling edge. It then checks at the following falling edge that `ts16_valid` has dropped and the byte has held. A select register write takes effect one edge after its strobe. The bench checks this by writing in the same cycle as a sample and expecting the old source there, then expecting the new source on the next sample. It sweeps all 16 frames, both mode settings and several select patterns, and computes each expected nibble from its own model of the select bits.

// File: rtl/tss_pkg.sv
package tss_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] sig;
    } ts16_out_t;
endpackage

// File: rtl/tss_sel_bank.sv
module tss_sel_bank #(
    parameter int N_CH  = 32,
    parameter int SEL_W = 8,
    localparam int N_REG  = N_CH / SEL_W,
    localparam int ADDR_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  wdata,
    output logic [N_CH-1:0]   sel_vec
);
    logic [N_CH-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        for (int k = 0; k < N_REG; k++) begin
            if (we && (int'(addr) == k)) begin
                sel_d[k*SEL_W +: SEL_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_vec = sel_q;
endmodule

// File: rtl/tss_nib_pick.sv
module tss_nib_pick
    import tss_pkg::*;
(
    input  logic             mode_en,
    input  logic             sel_bit,
    input  logic [NIB_W-1:0] ser_nib,
    input  logic [NIB_W-1:0] reg_nib,
    output logic [NIB_W-1:0] nib
);
    always_comb begin
        nib = (mode_en && sel_bit) ? reg_nib : ser_nib;
    end
endmodule

// File: rtl/tss_top.sv
module tss_top
    import tss_pkg::*;
#(
    parameter int N_CH     = 32,
    parameter int SEL_W    = 8,
    parameter int SLOT_W   = 5,
    parameter int FRAME_W  = 4,
    parameter int SIG_SLOT = 16,
    localparam int N_REG  = N_CH / SEL_W,
    localparam int ADDR_W = (N_REG > 1) ? $clog2(N_REG) : 1,
    localparam int HALF   = N_CH / 2,
    localparam int CH_W   = $clog2(N_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_en,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [SEL_W-1:0]   cfg_wdata,
    input  logic [SLOT_W-1:0]  slot_num,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic [BYTE_W-1:0]  ser_sig,
    input  logic [BYTE_W-1:0]  reg_sig,
    output logic               ts16_valid,
    output logic [BYTE_W-1:0]  ts16_byte
);
    logic [N_CH-1:0]   sel_vec;
    logic [CH_W-1:0]   up_idx;
    logic [CH_W-1:0]   ch_idx [2];
    logic [NIB_W-1:0]  pick   [2];
    logic [BYTE_W-1:0] merged;
    ts16_out_t         st_d, st_q;

    tss_sel_bank #(.N_CH(N_CH), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .sel_vec(sel_vec)
    );

    // Frame 0 reuses the channel-1 / channel-17 select bits for the alignment byte.
    always_comb begin
        if (frame_num == '0) up_idx = '0;
        else                 up_idx = CH_W'(frame_num) - CH_W'(1);
    end

    // h = 1 drives the upper nibble, h = 0 the lower nibble.
    for (genvar h = 0; h < 2; h++) begin : g_nib
        assign ch_idx[h] = (h == 1) ? up_idx : (up_idx + CH_W'(HALF));
        tss_nib_pick u_pick (
            .mode_en(mode_en),
            .sel_bit(sel_vec[ch_idx[h]]),
            .ser_nib(ser_sig[h*NIB_W +: NIB_W]),
            .reg_nib(reg_sig[h*NIB_W +: NIB_W]),
            .nib    (pick[h])
        );
        assign merged[h*NIB_W +: NIB_W] = pick[h];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (int'(slot_num) == SIG_SLOT) begin
            st_d.valid = 1'b1;
            st_d.sig   = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts16_valid = st_q.valid;
    assign ts16_byte  = st_q.sig;
endmodule

// File: rtl/tss_chk.sv
module tss_chk
    import tss_pkg::*;
#(
    parameter int N_CH     = 32,
    parameter int SLOT_W   = 5,
    parameter int FRAME_W  = 4,
    parameter int SIG_SLOT = 16,
    localparam int HALF = N_CH / 2,
    localparam int CH_W = $clog2(N_CH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_en,
    input logic [SLOT_W-1:0]  slot_num,
    input logic [FRAME_W-1:0] frame_num,
    input logic [BYTE_W-1:0]  ser_sig,
    input logic [BYTE_W-1:0]  reg_sig,
    input logic [N_CH-1:0]    sel_vec,
    input logic               ts16_valid,
    input logic [BYTE_W-1:0]  ts16_byte
);
    logic            at_slot;
    logic [CH_W-1:0] up_i;
    assign at_slot = (int'(slot_num) == SIG_SLOT);
    assign up_i    = CH_W'(frame_num) - CH_W'(1);

    a_r8_valid_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        at_slot |=> ts16_valid);

    a_r8_hold_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
        !at_slot |=> (!ts16_valid && $stable(ts16_byte)));

    a_r2_mode_off_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (at_slot && !mode_en) |=> (ts16_byte == $past(ser_sig)));

    a_r6_frame0_register: assert property (@(posedge clk) disable iff (!rst_n)
        (at_slot && mode_en && frame_num == '0 && sel_vec[0] && sel_vec[HALF])
        |=> (ts16_byte == $past(reg_sig)));

    a_r4_upper_register: assert property (@(posedge clk) disable iff (!rst_n)
        (at_slot && mode_en && frame_num != '0 && sel_vec[up_i])
        |=> (ts16_byte[BYTE_W-1:NIB_W] == $past(reg_sig[BYTE_W-1:NIB_W])));

    a_r3_upper_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (at_slot && mode_en && frame_num != '0 && !sel_vec[up_i])
        |=> (ts16_byte[BYTE_W-1:NIB_W] == $past(ser_sig[BYTE_W-1:NIB_W])));
endmodule

bind tss_top tss_chk #(
    .N_CH(N_CH), .SLOT_W(SLOT_W), .FRAME_W(FRAME_W), .SIG_SLOT(SIG_SLOT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .slot_num  (slot_num),
    .frame_num (frame_num),
    .ser_sig   (ser_sig),
    .reg_sig   (reg_sig),
    .sel_vec   (sel_vec),
    .ts16_valid(ts16_valid),
    .ts16_byte (ts16_byte)
);

// File: tb/sim_tss_top.sv
`timescale 1ns/1ps
module sim_tss_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [4:0] slot_num = 5'd0;
    logic [3:0] frame_num = '0;
    logic [7:0] ser_sig = '0;
    logic [7:0] reg_sig = '0;
    logic       ts16_valid;
    logic [7:0] ts16_byte;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [31:0] sel_m = '0;

    always #2 clk = ~clk;

    tss_top u0 (.*);

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [7:0] model(input logic m, input int f,
                                         input logic [7:0] s, input logic [7:0] r);
        int up;
        logic [7:0] e;
        up = (f == 0) ? 0 : f - 1;
        e[7:4] = (m && sel_m[up])      ? r[7:4] : s[7:4];
        e[3:0] = (m && sel_m[up + 16]) ? r[3:0] : s[3:0];
        return e;
    endfunction

    task automatic wr(input int k, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(k); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        sel_m[k*8 +: 8] = d;
    endtask

    task automatic load(input logic [31:0] p);
        for (int k = 0; k < 4; k++) wr(k, p[k*8 +: 8]);
    endtask

    // Sample at slot 16, result due at the next edge; then verify the hold cycle.
    task automatic frame_chk(input string req, input int f,
                             input logic [7:0] s, input logic [7:0] r);
        logic [7:0] e;
        @(negedge clk);
        slot_num = 5'd16; frame_num = 4'(f); ser_sig = s; reg_sig = r;
        e = model(mode_en, f, s, r);
        @(negedge clk);
        slot_num = 5'd3; ser_sig = ~s; reg_sig = ~r;
        chk({req, " byte"}, ts16_byte, e);
        chk("R8 valid pulse", {7'd0, ts16_valid}, 8'd1);
        @(negedge clk);
        chk("R8 hold", {ts16_valid, ts16_byte[6:0]}, {1'b0, e[6:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got=hung expected=finished");
        summary();
    end

    initial begin
        logic [31:0] pats [6];
        logic [7:0] e;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hAAAA_5555;
        pats[3] = 32'h0F0F_3C3C; pats[4] = 32'h0001_0001; pats[5] = 32'h8000_8000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", {7'd0, ts16_valid}, 8'd0);
        chk("R1 reset byte", ts16_byte, 8'h00);
        mode_en = 1'b1;
        for (int f = 0; f < 16; f++) frame_chk("R1 selects clear", f, 8'h5A ^ 8'(f*17), 8'hC3 + 8'(f*29));

        for (int p = 0; p < 6; p++) begin
            load(pats[p]);
            for (int m = 0; m < 2; m++) begin
                mode_en = m[0];
                for (int f = 0; f < 16; f++) begin
                    if (m == 0)      frame_chk("R2 mode off", f, 8'h39 + 8'(f*7), 8'hC6 ^ 8'(f*13));
                    else if (f == 0) frame_chk("R6 frame0", f, 8'h39 + 8'(p*5), 8'hC6 ^ 8'(p*9));
                    else if (p == 5) frame_chk("R5 ch16/ch32 no effect", f, 8'h12 + 8'(f), 8'hED - 8'(f));
                    else if (p == 2 || p == 3) frame_chk("R7 mixed nibbles R3 R4", f, 8'h39 + 8'(f*7), 8'hC6 ^ 8'(f*13));
                    else frame_chk("R5 channel map", f, 8'h39 + 8'(f*7), 8'hC6 ^ 8'(f*13));
                end
            end
        end

        // R9: write in the same cycle as a sample uses the old select bits.
        load(32'h0);
        mode_en = 1'b1;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'hFF;
        slot_num = 5'd16; frame_num = 4'd2; ser_sig = 8'h12; reg_sig = 8'hAB;
        @(negedge clk);
        cfg_we = 1'b0; slot_num = 5'd0;
        chk("R9 old selects on write cycle", ts16_byte, 8'h12);
        sel_m[7:0] = 8'hFF;
        e = model(1'b1, 2, 8'h12, 8'hAB);
        chk("R9 model new value", e, 8'hA2);
        frame_chk("R9 new selects", 2, 8'h12, 8'hAB);
        wr(3, 8'h01);
        frame_chk("R9 reg3 bit0 is ch25", 9, 8'h34, 8'hCD);
        summary();
    end
endmodule